// File: doc/BRIEF.md
# Dual-Clock Word Buffer with Programmable Level Flags

This block is a first-in first-out store for 9-bit words with a write side and a read side, each run by its own free-running clock. The two clocks may be the same net or fully unrelated. The write side holds the Full and Almost Full indications and the read side holds the Empty and Almost Empty indications. Every indication is an active-low output registered only in the domain that owns it. The read and write positions cross between domains as Gray codes through two-flop synchronizers.

A word is accepted only when both write qualifiers are in their active state, and it is delivered only when both read qualifiers are in their active state. The second write qualifier is sampled while reset is held and then takes one of two roles. It is either a plain second enable, or a select that sends write cycles to an external threshold register bank instead of the buffer. The two thresholds come in as inputs from that bank and are only compared against occupancy here. A tri-state control floats the data outputs. The depth is a power-of-two parameter, 256 words by default.

Top module: `twin_clock_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge only when `wen1_n` is 0 and `wen2_ld` is 1. Any other combination stores nothing. While both are held active, one word is stored on every edge.
- R2: A word is read on a rising `rd_clk` edge only when `ren1_n` and `ren2_n` are both 0. The word then appears on the output register after that edge, and words come out in the order they were written.
- R3: `empty_n` is 0 while the read domain sees no unread word. After a write into an empty buffer it rises on the third `rd_clk` edge after the write edge (clocks tied). It falls on the same edge that reads the last word.
- R4: `full_n` is 0 while DEPTH words are unread. Write attempts while `full_n` is 0 store nothing.
- R5: `aempty_n` is 0 when the unread count seen by the read domain is less than or equal to `ae_ofs`, and 1 otherwise.
- R6: `afull_n` is 0 when the unread count seen by the write domain is greater than or equal to DEPTH minus `af_ofs`, and 1 otherwise.
- R7: While `rst_n` is 0 and after it is released, the buffer is empty: `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, and the output register holds 0.
- R8: When `oe_n` is 1, `dout` is high impedance. When `oe_n` is 0, `dout` shows the output register.
- R9: If `wen2_ld` is 0 on the `wr_clk` edges during reset, load mode is selected. In load mode, `ofs_load` is 1 whenever `wen1_n`=0 and `wen2_ld`=0, and no word is stored. If `wen2_ld` is 1 during reset, `ofs_load` stays 0.
- R10: Read attempts while `empty_n` is 0 are ignored: the output register and the read position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wen1_n | input | 1 | Write qualifier, active low |
| wen2_ld | input | 1 | Second write qualifier (active high), or threshold-load select in load mode |
| din | input | 9 | Write data |
| ren1_n | input | 1 | Read qualifier, active low |
| ren2_n | input | 1 | Second read qualifier, active low |
| oe_n | input | 1 | Output drive control, active low |
| ae_ofs | input | log2(DEPTH) | Almost Empty threshold from the offset bank |
| af_ofs | input | log2(DEPTH) | Almost Full offset from the offset bank |
| dout | output | 9 | Read data, tri-state |
| empty_n | output | 1 | Empty indication, active low, read domain |
| aempty_n | output | 1 | Almost Empty indication, active low, read domain |
| full_n | output | 1 | Full indication, active low, write domain |
| afull_n | output | 1 | Almost Full indication, active low, write domain |
| ofs_load | output | 1 | Write cycle is directed to the offset bank |

## Verification
The bench ties both clocks to one 100 MHz clock, so every latency is a fixed number of edges. A read result is on the output register at the first falling edge after the read edge. Flags that depend only on the local position update on the edge of the operation itself. A flag that depends on the other side's position moves on the third edge after the operation: one register for the Gray position and two synchronizer stages. The latency checks sample at exactly the second and third falling edges after a write. The occupancy sweeps wait five idle cycles before comparing the flags, so both sides have settled when the arithmetic expectation is applied.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

    typedef enum logic {
        WMODE_ENABLE = 1'b0,
        WMODE_LOAD   = 1'b1
    } wmode_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;
endmodule

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
module dcfifo_ram #(
    parameter int DW = 9,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
`timescale 1ns/1ps
module dcfifo_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [PW-1:0] rgray_sync,
    input  logic [AW-1:0] af_ofs,
    output logic          store,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          full_n,
    output logic          afull_n,
    output logic          ofs_load,
    output wmode_e        mode
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full_n;
        logic          afull_n;
    } wst_t;

    wst_t   st_d, st_q;
    wmode_e mode_q;

    logic [PW-1:0] rbin_seen;
    logic [PW-1:0] used_next;
    logic          store_c;

    always_comb begin
        st_d      = st_q;
        rbin_seen = PW'(gray_to_bin(32'(rgray_sync)));
        store_c   = !wen1_n && wen2_ld && st_q.full_n;
        st_d.bin  = st_q.bin + PW'(store_c);
        st_d.gray = PW'(bin_to_gray(32'(st_d.bin)));
        used_next = st_d.bin - rbin_seen;
        st_d.full_n  = (used_next != DEPTH_P);
        st_d.afull_n = !(used_next >= (DEPTH_P - {1'b0, af_ofs}));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bin     <= '0;
            st_q.gray    <= '0;
            st_q.full_n  <= 1'b1;
            st_q.afull_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // role of the second write qualifier is latched while reset is held
    always_ff @(posedge wclk) begin
        if (!rst_n) mode_q <= wen2_ld ? WMODE_ENABLE : WMODE_LOAD;
    end

    assign store    = store_c;
    assign wbin     = st_q.bin;
    assign wgray    = st_q.gray;
    assign full_n   = st_q.full_n;
    assign afull_n  = st_q.afull_n;
    assign ofs_load = (mode_q == WMODE_LOAD) && !wen1_n && !wen2_ld;
    assign mode     = mode_q;
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
`timescale 1ns/1ps
module dcfifo_rd_ctrl
    import dcfifo_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [PW-1:0] wgray_sync,
    input  logic [AW-1:0] ae_ofs,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic          empty_n,
    output logic          aempty_n,
    output logic [DW-1:0] q_reg
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty_n;
        logic          aempty_n;
        logic [DW-1:0] q;
    } rst_t;

    rst_t st_d, st_q;

    logic [PW-1:0] wbin_seen;
    logic [PW-1:0] avail_next;
    logic          fire;

    always_comb begin
        st_d       = st_q;
        wbin_seen  = PW'(gray_to_bin(32'(wgray_sync)));
        fire       = !ren1_n && !ren2_n && st_q.empty_n;
        st_d.bin   = st_q.bin + PW'(fire);
        st_d.gray  = PW'(bin_to_gray(32'(st_d.bin)));
        avail_next = wbin_seen - st_d.bin;
        st_d.empty_n  = (avail_next != '0);
        st_d.aempty_n = (avail_next > {1'b0, ae_ofs});
        if (fire) st_d.q = mem_rdata;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bin      <= '0;
            st_q.gray     <= '0;
            st_q.empty_n  <= 1'b0;
            st_q.aempty_n <= 1'b0;
            st_q.q        <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr    = st_q.bin[AW-1:0];
    assign rbin     = st_q.bin;
    assign rgray    = st_q.gray;
    assign empty_n  = st_q.empty_n;
    assign aempty_n = st_q.aempty_n;
    assign q_reg    = st_q.q;
endmodule

// File: rtl/twin_clock_fifo.sv
`timescale 1ns/1ps
module twin_clock_fifo
    import dcfifo_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [DW-1:0] din,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic          oe_n,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          full_n,
    output logic          afull_n,
    output logic          ofs_load
);
    localparam int PW = AW + 1;

    logic          store;
    logic [PW-1:0] wr_bin, wr_gray, wr_gray_rs;
    logic [PW-1:0] rd_bin, rd_gray, rd_gray_ws;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] q_reg;
    wmode_e        wr_mode;

    dcfifo_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wclk       (wr_clk),
        .rst_n      (rst_n),
        .wen1_n     (wen1_n),
        .wen2_ld    (wen2_ld),
        .rgray_sync (rd_gray_ws),
        .af_ofs     (af_ofs),
        .store      (store),
        .wbin       (wr_bin),
        .wgray      (wr_gray),
        .full_n     (full_n),
        .afull_n    (afull_n),
        .ofs_load   (ofs_load),
        .mode       (wr_mode)
    );

    dcfifo_rd_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .rclk       (rd_clk),
        .rst_n      (rst_n),
        .ren1_n     (ren1_n),
        .ren2_n     (ren2_n),
        .wgray_sync (wr_gray_rs),
        .ae_ofs     (ae_ofs),
        .mem_rdata  (mem_rdata),
        .raddr      (rd_addr),
        .rbin       (rd_bin),
        .rgray      (rd_gray),
        .empty_n    (empty_n),
        .aempty_n   (aempty_n),
        .q_reg      (q_reg)
    );

    dcfifo_sync #(.W(PW)) u_w2r (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .async_in (wr_gray),
        .sync_out (wr_gray_rs)
    );

    dcfifo_sync #(.W(PW)) u_r2w (
        .clk      (wr_clk),
        .rst_n    (rst_n),
        .async_in (rd_gray),
        .sync_out (rd_gray_ws)
    );

    dcfifo_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (store),
        .waddr (wr_bin[AW-1:0]),
        .wdata (din),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    assign dout = oe_n ? {DW{1'bz}} : q_reg;
endmodule

// File: rtl/dcfifo_chk.sv
`timescale 1ns/1ps
module dcfifo_chk #(
    parameter int DW = 9,
    parameter int PW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wen1_n,
    input logic          wen2_ld,
    input logic          ren1_n,
    input logic          ren2_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          ofs_load,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] rd_bin,
    input logic [DW-1:0] q_reg
);
    a_r1_store_needs_enables: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wen1_n || !wen2_ld) |=> $stable(wr_bin));

    a_r4_no_write_when_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wr_bin));

    a_r10_no_read_when_empty: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_bin));

    a_r2_q_holds_without_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n || ren1_n || ren2_n) |=> $stable(q_reg));

    a_r5_empty_implies_aempty: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    a_r6_full_implies_afull: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    a_r9_no_store_on_load: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ofs_load |=> $stable(wr_bin));
endmodule

bind twin_clock_fifo dcfifo_chk #(.DW(DW), .PW(AW + 1)) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .wen1_n   (wen1_n),
    .wen2_ld  (wen2_ld),
    .ren1_n   (ren1_n),
    .ren2_n   (ren2_n),
    .empty_n  (empty_n),
    .aempty_n (aempty_n),
    .full_n   (full_n),
    .afull_n  (afull_n),
    .ofs_load (ofs_load),
    .wr_bin   (wr_bin),
    .rd_bin   (rd_bin),
    .q_reg    (q_reg)
);

// File: tb/twin_clock_fifo_bench.sv
`timescale 1ns/1ps
module twin_clock_fifo_bench;
    localparam int DW    = 9;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
    logic [DW-1:0] din;
    logic [AW-1:0] ae_ofs, af_ofs;
    wire  [DW-1:0] dout;
    logic          empty_n, aempty_n, full_n, afull_n, ofs_load;

    int total = 0;
    int bad   = 0;
    int wr_idx = 0;
    int rd_idx = 0;
    int occ = 0;

    always #5 clk = ~clk;

    twin_clock_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_twin_clock_fifo (
        .wr_clk (clk), .rd_clk (clk), .rst_n (rst_n),
        .wen1_n (wen1_n), .wen2_ld (wen2_ld), .din (din),
        .ren1_n (ren1_n), .ren2_n (ren2_n), .oe_n (oe_n),
        .ae_ofs (ae_ofs), .af_ofs (af_ofs), .dout (dout),
        .empty_n (empty_n), .aempty_n (aempty_n),
        .full_n (full_n), .afull_n (afull_n), .ofs_load (ofs_load)
    );

    function automatic logic [DW-1:0] word_of(input int k);
        return DW'((k * 37 + 5) % 512);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(input logic [DW-1:0] v);
        @(negedge clk);
        din = v; wen1_n = 1'b0; wen2_ld = 1'b1;
        @(negedge clk);
        wen1_n = 1'b1;
    endtask

    task automatic take();
        @(negedge clk);
        ren1_n = 1'b0; ren2_n = 1'b0;
        @(negedge clk);
        ren1_n = 1'b1; ren2_n = 1'b1;
    endtask

    task automatic do_reset(input logic load_mode);
        @(negedge clk);
        rst_n = 1'b0; wen2_ld = !load_mode; wen1_n = 1'b1;
        idle(3);
        rst_n = 1'b1; wen2_ld = 1'b1;
        occ = 0; rd_idx = wr_idx;
    endtask

    task automatic check_flags(input string tag, input int n, input int m);
        chk({tag, " R3 empty_n"},  int'(empty_n),  int'(occ != 0));
        chk({tag, " R4 full_n"},   int'(full_n),   int'(occ != DEPTH));
        chk({tag, " R5 aempty_n"}, int'(aempty_n), int'(occ > n));
        chk({tag, " R6 afull_n"},  int'(afull_n),  int'(!(occ >= DEPTH - m)));
    endtask

    task automatic sweep(input int n, input int m);
        ae_offs_set(n, m);
        for (int k = 0; k <= DEPTH; k++) begin
            idle(5);
            check_flags("fill", n, m);
            if (k < DEPTH) begin put(word_of(wr_idx)); wr_idx++; occ++; end
        end
        put(9'h1AA);               // R4: rejected while full
        idle(5);
        chk("R4 full holds after write at full", int'(full_n), 0);
        for (int k = 0; k < DEPTH; k++) begin
            take(); occ--;
            chk("R2 data order", int'(dout), int'(word_of(rd_idx)));
            rd_idx++;
            idle(5);
            check_flags("drain", n, m);
        end
    endtask

    task automatic ae_offs_set(input int n, input int m);
        @(negedge clk);
        ae_ofs = AW'(n); af_ofs = AW'(m);
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wen1_n = 1'b1; wen2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        oe_n = 1'b0; din = '0; ae_ofs = 4'd7; af_ofs = 4'd7;
        do_reset(1'b0);
        @(negedge clk);
        // R7 reset state
        chk("R7 empty_n",  int'(empty_n), 0);
        chk("R7 aempty_n", int'(aempty_n), 0);
        chk("R7 full_n",   int'(full_n), 1);
        chk("R7 afull_n",  int'(afull_n), 1);
        chk("R7 q",        int'(dout), 0);

        // R1 partial qualifiers store nothing; R9 enable mode never loads
        wen1_n = 1'b0; wen2_ld = 1'b0;
        #1 chk("R9 ofs_load in enable mode", int'(ofs_load), 0);
        @(negedge clk);
        wen1_n = 1'b1; wen2_ld = 1'b1;
        @(negedge clk);
        wen2_ld = 1'b1;
        idle(5);
        chk("R1 no store on partial enables", int'(empty_n), 0);

        // R10 reads while empty ignored
        ren1_n = 1'b0; ren2_n = 1'b0;
        idle(3);
        ren1_n = 1'b1; ren2_n = 1'b1;
        idle(5);
        chk("R10 q holds on empty read", int'(dout), 0);
        put(word_of(wr_idx)); wr_idx++;
        @(negedge clk);
        chk("R3 empty_n one edge after write", int'(empty_n), 0);
        @(negedge clk);
        chk("R3 empty_n two edges after write", int'(empty_n), 0);
        @(negedge clk);
        chk("R3 empty_n three edges after write", int'(empty_n), 1);
        take();
        chk("R2 first word", int'(dout), int'(word_of(rd_idx)));
        rd_idx++;
        chk("R3 empty_n on last read edge", int'(empty_n), 0);

        // R1 continuous writes, one per edge
        @(negedge clk);
        wen1_n = 1'b0; wen2_ld = 1'b1;
        for (int k = 0; k < 3; k++) begin din = word_of(wr_idx); wr_idx++; @(negedge clk); end
        wen1_n = 1'b1;
        idle(5);
        for (int k = 0; k < 3; k++) begin
            take();
            chk("R1 burst word", int'(dout), int'(word_of(rd_idx)));
            rd_idx++;
        end
        idle(5);
        chk("R1 burst drained", int'(empty_n), 0);

        sweep(7, 7);
        sweep(3, 5);

        // R8 output drive
        @(negedge clk); oe_n = 1'b1;
        #1 chk("R8 float when disabled", int'(dout === {DW{1'bz}}), 1);
        @(negedge clk); oe_n = 1'b0;
        #1 chk("R8 drive when enabled", int'(dout), int'(word_of(rd_idx - 1)));

        // R9 load mode
        do_reset(1'b1);
        @(negedge clk);
        wen1_n = 1'b0; wen2_ld = 1'b0;
        #1 chk("R9 ofs_load in load mode", int'(ofs_load), 1);
        @(negedge clk);
        wen1_n = 1'b1; wen2_ld = 1'b1;
        #1 chk("R9 ofs_load idle", int'(ofs_load), 0);
        idle(5);
        chk("R9 load cycle stores nothing", int'(empty_n), 0);
        put(word_of(wr_idx)); wr_idx++;
        idle(5);
        chk("R9 store still works in load mode", int'(empty_n), 1);
        take();
        chk("R9 load mode data", int'(dout), int'(word_of(rd_idx)));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule